// File: doc/BRIEF.md
# Speculative Lock Elision Controller

This block sits beside the retirement stage of one core and watches the stream of retired memory operations. A lock acquire shows up as a load-linked of a lock word followed by a store-conditional that writes 1 to the same address. When the controller sees this pair, it predicts that the lock is not needed. It suppresses the store-conditional, asks for a single register checkpoint and enters a speculative critical section.

Inside the section, stores are held in a small coalescing write buffer, and the lines that are read are recorded as tags in a read-set table. A plain store of 0 to the lock address ends the section. That store is also suppressed, since it would only undo the acquire, and the buffered stores then drain to memory one per cycle in allocation order.

An external coherence request that touches the speculative footprint aborts the section. Running out of buffer or table space also aborts it, and so does an uncached access. On an abort the controller discards all speculative state in one cycle and pulses a rollback request. Outside a critical section, stores pass straight through to the memory port.

Top module: `sle_ctrl`

## Requirements
- R1: A load-linked (kind 2) followed by a store-conditional (kind 3) with data 1 to the same address, with no other memory operation between them, is elided. The store-conditional does not reach `mem_valid_o`. `ckpt_o` is high for exactly the one cycle after the store-conditional is presented, and `spec_o` is high from that same cycle.
- R2: Outside a critical section, a store (kind 1) or store-conditional appears on the memory port in the cycle after it is presented. A store-conditional with data other than 1, with a different address, or preceded by another memory operation after the load-linked is written as an ordinary store, and no checkpoint is requested.
- R3: During a critical section, a store of 0 to the lock address ends the section (`spec_o` low in the next cycle). Neither that store nor the acquire store ever reaches memory.
- R4: No memory write is issued while `spec_o` is high.
- R5: Repeated stores to the same word address inside a section occupy one buffer entry, and only the last value is written at commit.
- R6: After the release, the buffered stores are written one per cycle on consecutive cycles, in the order their addresses were first stored.
- R7: An external invalidation (`snp_inv_i`=1) to the line of any word read in the section, any word written in the section, or the lock word causes an abort. An invalidation to any other line has no effect.
- R8: An external read request (`snp_inv_i`=0) causes an abort only when its line holds a word written in the section. A read request to a line that was only read has no effect.
- R9: An abort also occurs on a store to a new word address when the buffer already holds WB_DEPTH entries, on a load of a new line when the read-set table already holds RS_DEPTH lines, and on any uncached operation inside the section.
- R10: An abort raises `rollback_o` for exactly the one cycle after the trigger and drops `spec_o`. No buffered store from the aborted section ever reaches memory, and the next section starts with an empty buffer.
- R11: While buffered stores are draining, no new elision starts. A load-linked is ignored, and stores that arrive are written after the drained entries in arrival order.
- R12: While reset is asserted, `mem_valid_o`, `ckpt_o`, `rollback_o` and `spec_o` are low.

Line address is the word address with its low OFFW bits (default 4) dropped. A line address has AW-OFFW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | A retired memory operation is presented |
| op_kind_i | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| op_uncached_i | input | 1 | Operation targets uncached space |
| op_addr_i | input | AW | Word address of the operation |
| op_data_i | input | DW | Store data |
| snp_valid_i | input | 1 | External coherence request present |
| snp_inv_i | input | 1 | 1 invalidation, 0 read request |
| snp_line_i | input | AW-OFFW | Line address of the external request |
| mem_valid_o | output | 1 | Store write to memory |
| mem_addr_o | output | AW | Store address |
| mem_data_o | output | DW | Store data |
| ckpt_o | output | 1 | Register checkpoint request pulse |
| rollback_o | output | 1 | Register rollback request pulse |
| spec_o | output | 1 | Critical section is being executed speculatively |

## Verification
The hardest state to reach from the ports is the draining phase with fresh traffic on top of it. It requires a committed section whose buffer is still emptying while a load-linked, a store-conditional of 1 and a plain store arrive back to back. A directed sequence issues these right after the release, so that none of them can start an elision and all of them land behind the drained entries. Random sections mix stores to a small address pool, loads to a small line pool and snoops of both kinds. Overflow of the buffer and of the table, merges, and conflicts on shared lines therefore all arise naturally, and a bench model predicts either the exact commit stream or an abort.

// File: rtl/sle_pkg.sv
package sle_pkg;
  typedef enum logic [1:0] {
    OP_LD = 2'd0,
    OP_ST = 2'd1,
    OP_LL = 2'd2,
    OP_SC = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ARMED,
    S_SPEC,
    S_DRAIN
  } sle_state_e;
endpackage

// File: rtl/sle_wbuf.sv
// Coalescing speculative store buffer, ring ordered; DEPTH must be a power of two.
module sle_wbuf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int OFFW  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 wr_i,
  input  logic                 merge_en_i,
  input  logic                 pop_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        data_i,
  input  logic [AW-OFFW-1:0]   snp_line_i,
  output logic                 ovf_o,
  output logic                 empty_o,
  output logic                 snp_hit_o,
  output logic [AW-1:0]        head_addr_o,
  output logic [DW-1:0]        head_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;

  logic [DEPTH-1:0] hit_v, snp_v;
  logic [PW-1:0]    hit_idx;
  logic             hit, full, push, pop_do;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_v[g] = vld_q[g] && (addr_q[g] == addr_i);
    assign snp_v[g] = vld_q[g] && (addr_q[g][AW-1:OFFW] == snp_line_i);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_v[i]) hit_idx = PW'(i);
    end
  end

  assign hit         = merge_en_i && (|hit_v);
  assign full        = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign pop_do      = pop_i && !empty_o;
  assign push        = wr_i && !hit && (!full || pop_do);
  assign ovf_o       = wr_i && !hit && full && !pop_do;
  assign snp_hit_o   = |snp_v;
  assign head_addr_o = addr_q[rd_q];
  assign head_data_o = data_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop_do) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= rd_q + 1'b1;
      end
      if (push) begin
        vld_q[wr_q] <= 1'b1;
        wr_q        <= wr_q + 1'b1;
      end
      cnt_q <= cnt_q + CW'(push) - CW'(pop_do);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!clr_i) begin
      if (wr_i && hit) data_q[hit_idx] <= data_i;
      if (push) begin
        addr_q[wr_q] <= addr_i;
        data_q[wr_q] <= data_i;
      end
    end
  end
endmodule

// File: rtl/sle_rset.sv
// Read-set line tag table, filled in order, cleared at once.
module sle_rset #(
  parameter int LW    = 28,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ins_i,
  input  logic [LW-1:0] line_i,
  input  logic [LW-1:0] snp_line_i,
  output logic          ovf_o,
  output logic          snp_hit_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [LW-1:0]    tag_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [CW-1:0]    cnt_q;
  logic [DEPTH-1:0] hit_v, snp_v;
  logic             hit, full, ins;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_v[g] = vld_q[g] && (tag_q[g] == line_i);
    assign snp_v[g] = vld_q[g] && (tag_q[g] == snp_line_i);
  end

  assign hit       = |hit_v;
  assign full      = (cnt_q == CW'(DEPTH));
  assign ins       = ins_i && !hit && !full;
  assign ovf_o     = ins_i && !hit && full;
  assign snp_hit_o = |snp_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else if (ins) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cnt_q == CW'(i)) vld_q[i] <= 1'b1;
      end
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ins && !clr_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cnt_q == CW'(i)) tag_q[i] <= line_i;
      end
    end
  end
endmodule

// File: rtl/sle_ctrl.sv
module sle_ctrl
  import sle_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int OFFW     = 4,
  parameter int WB_DEPTH = 4,
  parameter int RS_DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [1:0]         op_kind_i,
  input  logic               op_uncached_i,
  input  logic [AW-1:0]      op_addr_i,
  input  logic [DW-1:0]      op_data_i,
  input  logic               snp_valid_i,
  input  logic               snp_inv_i,
  input  logic [AW-OFFW-1:0] snp_line_i,
  output logic               mem_valid_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_data_o,
  output logic               ckpt_o,
  output logic               rollback_o,
  output logic               spec_o
);
  localparam int LW = AW - OFFW;

  sle_state_e    state_q, state_d;
  op_kind_e      kind;
  logic [AW-1:0] lock_q;

  logic st_op, ld_op, in_spec, in_drain, passive, lock_addr_hit, lock_snp;
  logic elide, rel, spec_st, spec_ld, unc_abort, snp_abort, abort, pass_st, arm;
  logic wb_ovf, wb_empty, wb_snp, wb_wr, wb_pop, rs_ovf, rs_snp;
  logic [AW-1:0] wb_head_addr;
  logic [DW-1:0] wb_head_data;

  assign kind          = op_kind_e'(op_kind_i);
  assign st_op         = op_valid_i && (kind == OP_ST || kind == OP_SC);
  assign ld_op         = op_valid_i && (kind == OP_LD || kind == OP_LL);
  assign in_spec       = (state_q == S_SPEC);
  assign in_drain      = (state_q == S_DRAIN);
  assign passive       = (state_q == S_IDLE) || (state_q == S_ARMED);
  assign lock_addr_hit = (op_addr_i == lock_q);
  assign lock_snp      = (snp_line_i == lock_q[AW-1:OFFW]);
  assign arm           = op_valid_i && kind == OP_LL && !op_uncached_i;

  assign elide = (state_q == S_ARMED) && op_valid_i && kind == OP_SC && !op_uncached_i
                 && lock_addr_hit && (op_data_i == DW'(1));
  assign rel   = in_spec && op_valid_i && kind == OP_ST && !op_uncached_i
                 && lock_addr_hit && (op_data_i == '0);

  assign spec_st   = in_spec && st_op && !op_uncached_i && !rel;
  // lock line is watched separately, so it never takes a read-set slot
  assign spec_ld   = in_spec && ld_op && !op_uncached_i
                     && (op_addr_i[AW-1:OFFW] != lock_q[AW-1:OFFW]);
  assign unc_abort = op_valid_i && op_uncached_i;
  assign snp_abort = snp_valid_i && (snp_inv_i ? (rs_snp || wb_snp || lock_snp) : wb_snp);
  assign abort     = in_spec && (snp_abort || unc_abort || wb_ovf || rs_ovf);
  assign pass_st   = passive && st_op && !elide;

  assign wb_wr  = spec_st || (in_drain && st_op);
  assign wb_pop = in_drain && !wb_empty;

  sle_wbuf #(
    .AW(AW), .DW(DW), .DEPTH(WB_DEPTH), .OFFW(OFFW)
  ) i_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (abort),
    .wr_i        (wb_wr),
    .merge_en_i  (in_spec),
    .pop_i       (wb_pop),
    .addr_i      (op_addr_i),
    .data_i      (op_data_i),
    .snp_line_i  (snp_line_i),
    .ovf_o       (wb_ovf),
    .empty_o     (wb_empty),
    .snp_hit_o   (wb_snp),
    .head_addr_o (wb_head_addr),
    .head_data_o (wb_head_data)
  );

  sle_rset #(
    .LW(LW), .DEPTH(RS_DEPTH)
  ) i_rset (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (abort || rel),
    .ins_i      (spec_ld),
    .line_i     (op_addr_i[AW-1:OFFW]),
    .snp_line_i (snp_line_i),
    .ovf_o      (rs_ovf),
    .snp_hit_o  (rs_snp)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (arm) state_d = S_ARMED;
      S_ARMED: begin
        if (elide)           state_d = S_SPEC;
        else if (arm)        state_d = S_ARMED;
        else if (op_valid_i) state_d = S_IDLE;
      end
      S_SPEC: begin
        if (abort)    state_d = S_IDLE;
        else if (rel) state_d = S_DRAIN;
      end
      S_DRAIN: if (wb_empty && !st_op) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      lock_q      <= '0;
      mem_valid_o <= 1'b0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
      ckpt_o      <= 1'b0;
      rollback_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      ckpt_o     <= elide;
      rollback_o <= abort;
      if (passive && arm) lock_q <= op_addr_i;
      if (wb_pop) begin
        mem_valid_o <= 1'b1;
        mem_addr_o  <= wb_head_addr;
        mem_data_o  <= wb_head_data;
      end else if (pass_st) begin
        mem_valid_o <= 1'b1;
        mem_addr_o  <= op_addr_i;
        mem_data_o  <= op_data_i;
      end else begin
        mem_valid_o <= 1'b0;
      end
    end
  end

  assign spec_o = in_spec;
endmodule

// File: rtl/sle_chk.sv
module sle_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mem_valid_o,
  input logic ckpt_o,
  input logic rollback_o,
  input logic spec_o
);
  assert_ckpt_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_o |=> !ckpt_o);

  assert_ckpt_enters_spec_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_o |-> spec_o);

  assert_no_write_in_spec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_o |-> !mem_valid_o);

  assert_rollback_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_o |=> !rollback_o);

  assert_rollback_exits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_o |-> !spec_o);
endmodule

bind sle_ctrl sle_chk i_sle_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_valid_o (mem_valid_o),
  .ckpt_o      (ckpt_o),
  .rollback_o  (rollback_o),
  .spec_o      (spec_o)
);

// File: tb/test_sle_ctrl.sv
`timescale 1ns/1ps
module test_sle_ctrl;
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_LL = 2'd2, K_SC = 2'd3;
  localparam logic [31:0] LOCK = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_unc = 1'b0, snp_valid = 1'b0, snp_inv = 1'b0;
  logic [1:0] op_kind = '0;
  logic [31:0] op_addr = '0, op_data = '0;
  logic [27:0] snp_line = '0;
  logic mem_valid_o, ckpt_o, rollback_o, spec_o;
  logic [31:0] mem_addr_o, mem_data_o;

  int n_chk = 0, n_err = 0, cyc = 0, roll_cnt = 0, ckpt_cnt = 0;
  logic [31:0] q_addr[$], q_data[$];
  int q_cyc[$];
  logic [31:0] m_wa[$], m_wd[$];
  logic [27:0] m_rl[$];

  sle_ctrl i_sle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_kind_i(op_kind),
    .op_uncached_i(op_unc), .op_addr_i(op_addr), .op_data_i(op_data),
    .snp_valid_i(snp_valid), .snp_inv_i(snp_inv), .snp_line_i(snp_line),
    .mem_valid_o(mem_valid_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .ckpt_o(ckpt_o), .rollback_o(rollback_o), .spec_o(spec_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_valid_o) begin
        q_addr.push_back(mem_addr_o);
        q_data.push_back(mem_data_o);
        q_cyc.push_back(cyc);
      end
      if (rollback_o) roll_cnt++;
      if (ckpt_o) ckpt_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d, input bit u = 1'b0);
    op_valid = 1'b1; op_kind = k; op_addr = a; op_data = d; op_unc = u;
    @(posedge clk); #1;
    op_valid = 1'b0; op_unc = 1'b0;
  endtask

  task automatic snp(input bit inv, input logic [31:0] a);
    snp_valid = 1'b1; snp_inv = inv; snp_line = a[31:4];
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic acquire();
    op(K_LL, LOCK, 32'h0);
    op(K_SC, LOCK, 32'h1);
  endtask

  task automatic clear_log();
    q_addr.delete(); q_data.delete(); q_cyc.delete();
  endtask

  // compares the observed write log with the model list
  task automatic check_log(input string req, input bit consec);
    chk(q_addr.size() == m_wa.size(), req, q_addr.size(), m_wa.size());
    for (int i = 0; i < q_addr.size() && i < m_wa.size(); i++) begin
      chk(q_addr[i] == m_wa[i], req, q_addr[i], m_wa[i]);
      chk(q_data[i] == m_wd[i], req, q_data[i], m_wd[i]);
      if (consec && i > 0) chk(q_cyc[i] == q_cyc[i-1] + 1, req, q_cyc[i], q_cyc[i-1] + 1);
    end
  endtask

  function automatic logic [31:0] wpool(input int i);
    return (i < 2) ? 32'h200 + 32'(i) * 4 : 32'h200 + 32'(i) * 32'h100;
  endfunction

  function automatic logic [31:0] rpool(input int i);
    return 32'h800 + 32'(i) * 32'h100;
  endfunction

  function automatic bit model_store(input logic [31:0] a, input logic [31:0] d);
    for (int i = 0; i < m_wa.size(); i++)
      if (m_wa[i] == a) begin m_wd[i] = d; return 1'b0; end
    if (m_wa.size() == 4) return 1'b1;
    m_wa.push_back(a); m_wd.push_back(d);
    return 1'b0;
  endfunction

  function automatic bit model_load(input logic [31:0] a);
    for (int i = 0; i < m_rl.size(); i++) if (m_rl[i] == a[31:4]) return 1'b0;
    if (m_rl.size() == 4) return 1'b1;
    m_rl.push_back(a[31:4]);
    return 1'b0;
  endfunction

  function automatic bit model_snoop(input bit inv, input logic [31:0] a);
    bit wl = 1'b0, rl = 1'b0;
    for (int i = 0; i < m_wa.size(); i++) if (m_wa[i][31:4] == a[31:4]) wl = 1'b1;
    for (int i = 0; i < m_rl.size(); i++) if (m_rl[i] == a[31:4]) rl = 1'b1;
    if (inv) return wl || rl || (a[31:4] == LOCK[31:4]);
    return wl;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base_roll, base_ckpt;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!mem_valid_o && !ckpt_o && !rollback_o && !spec_o, "R12 reset outputs", {mem_valid_o, ckpt_o, rollback_o, spec_o}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 pass-through store
    clear_log();
    op(K_ST, 32'h300, 32'h9);
    chk(mem_valid_o && mem_addr_o == 32'h300 && mem_data_o == 32'h9, "R2 pass store", mem_addr_o, 32'h300);
    // R2 intervening store disarms; SC then written normally
    base_ckpt = ckpt_cnt;
    op(K_LL, LOCK, 0); op(K_ST, 32'h304, 32'h5); op(K_SC, LOCK, 32'h1);
    chk(mem_valid_o && mem_addr_o == LOCK && mem_data_o == 32'h1 && !spec_o, "R2 disarmed SC written", mem_addr_o, LOCK);
    // R2 SC writing 2 is not an acquire
    op(K_LL, LOCK, 0); op(K_SC, LOCK, 32'h2);
    chk(mem_valid_o && mem_data_o == 32'h2 && !spec_o, "R2 SC data 2 written", mem_data_o, 32'h2);
    idle(1);
    chk(ckpt_cnt == base_ckpt, "R2 no checkpoint", ckpt_cnt, base_ckpt);

    // R1/R3 elide empty section
    clear_log();
    acquire();
    chk(ckpt_o && spec_o, "R1 checkpoint and spec", {ckpt_o, spec_o}, 2'b11);
    idle(1);
    chk(!ckpt_o && spec_o, "R1 checkpoint one cycle", ckpt_o, 0);
    op(K_ST, LOCK, 32'h0);
    chk(!spec_o, "R3 release ends section", spec_o, 0);
    idle(3);
    chk(q_addr.size() == 0, "R3 lock stores suppressed", q_addr.size(), 0);

    // R5/R4/R6 merging and drain order
    clear_log(); m_wa.delete(); m_wd.delete();
    acquire();
    op(K_ST, 32'h200, 32'h1); op(K_ST, 32'h200, 32'h2); op(K_ST, 32'h400, 32'h3);
    chk(spec_o && !mem_valid_o, "R4 held in spec", mem_valid_o, 0);
    op(K_ST, LOCK, 32'h0);
    idle(5);
    m_wa = '{32'h200, 32'h400}; m_wd = '{32'h2, 32'h3};
    check_log("R5 merge R6 order", 1'b1);

    // R7 invalidation checks
    clear_log();
    acquire(); op(K_LD, 32'h800, 0);
    snp(1'b1, 32'h900);
    chk(spec_o && !rollback_o, "R7 unrelated invalidation ignored", spec_o, 1);
    snp(1'b1, 32'h108);
    chk(rollback_o && !spec_o, "R7 lock line invalidation aborts", rollback_o, 1);
    idle(1);
    chk(!rollback_o, "R10 rollback one cycle", rollback_o, 0);
    acquire(); op(K_LD, 32'h808, 0);
    snp(1'b1, 32'h800);
    chk(rollback_o, "R7 read line invalidation aborts", rollback_o, 1);

    // R8 read requests
    clear_log();
    acquire(); op(K_LD, 32'h800, 0); op(K_ST, 32'h400, 32'h7);
    snp(1'b0, 32'h800);
    chk(spec_o && !rollback_o, "R8 read req to read line ignored", spec_o, 1);
    snp(1'b0, 32'h40C);
    chk(rollback_o && !spec_o, "R8 read req to written line aborts", rollback_o, 1);
    idle(3);
    chk(q_addr.size() == 0, "R10 aborted stores discarded", q_addr.size(), 0);

    // R9 buffer overflow, then R10 fresh section
    acquire();
    op(K_ST, 32'h200, 1); op(K_ST, 32'h400, 2); op(K_ST, 32'h500, 3); op(K_ST, 32'h600, 4);
    chk(spec_o, "R9 full buffer still speculative", spec_o, 1);
    op(K_ST, 32'h700, 5);
    chk(rollback_o && !spec_o, "R9 buffer overflow aborts", rollback_o, 1);
    clear_log();
    acquire(); op(K_ST, 32'h300, 32'hE); op(K_ST, LOCK, 0);
    idle(4);
    m_wa = '{32'h300}; m_wd = '{32'hE};
    check_log("R10 fresh buffer", 1'b1);
    // R9 uncached and read-set overflow
    acquire(); op(K_LD, 32'h800, 0, 1'b1);
    chk(rollback_o, "R9 uncached aborts", rollback_o, 1);
    acquire();
    for (int i = 0; i < 4; i++) op(K_LD, rpool(i), 0);
    chk(spec_o, "R9 full read set still speculative", spec_o, 1);
    op(K_LD, rpool(4), 0);
    chk(rollback_o, "R9 read set overflow aborts", rollback_o, 1);

    // R11 activity during drain
    clear_log(); idle(2);
    base_ckpt = ckpt_cnt;
    acquire();
    op(K_ST, 32'h200, 32'hA); op(K_ST, 32'h400, 32'hB); op(K_ST, 32'h500, 32'hC);
    op(K_ST, LOCK, 0);
    op(K_LL, LOCK, 0); op(K_SC, LOCK, 32'h1); op(K_ST, 32'h600, 32'hD);
    chk(!spec_o, "R11 no elision in drain", spec_o, 0);
    idle(6);
    chk(ckpt_cnt == base_ckpt + 1, "R11 single checkpoint", ckpt_cnt, base_ckpt + 1);
    m_wa = '{32'h200, 32'h400, 32'h500, LOCK, 32'h600};
    m_wd = '{32'hA, 32'hB, 32'hC, 32'h1, 32'hD};
    check_log("R11 drain then appended R6", 1'b1);

    // random sections
    for (int it = 0; it < 80; it++) begin
      int n, r, k;
      bit ab;
      logic [31:0] a, d;
      bit inv;
      clear_log(); m_wa.delete(); m_wd.delete(); m_rl.delete();
      ab = 1'b0;
      base_roll = roll_cnt;
      acquire();
      n = $urandom_range(1, 8);
      for (int j = 0; j < n && !ab; j++) begin
        r = $urandom_range(0, 9);
        if (r < 5) begin
          a = wpool($urandom_range(0, 5)); d = $urandom;
          ab = model_store(a, d);
          op(K_ST, a, d);
        end else if (r < 8) begin
          a = rpool($urandom_range(0, 4));
          ab = model_load(a);
          op(K_LD, a, 0);
        end else begin
          k = $urandom_range(0, 11);
          a = (k < 6) ? wpool(k) : (k < 11) ? rpool(k - 6) : LOCK;
          inv = 1'($urandom_range(0, 1));
          ab = model_snoop(inv, a);
          snp(inv, a);
        end
      end
      if (!ab) begin
        op(K_ST, LOCK, 0);
        idle(m_wa.size() + 3);
        check_log("R6 random commit", 1'b1);
        chk(roll_cnt == base_roll, "R7 R8 R9 random no abort", roll_cnt, base_roll);
      end else begin
        idle(3);
        chk(q_addr.size() == 0, "R10 random abort discards", q_addr.size(), 0);
        chk(roll_cnt == base_roll + 1, "R10 random one rollback", roll_cnt, base_roll + 1);
      end
    end

    summary();
    $finish;
  end
endmodule